// File: doc/BRIEF.md
# Raw IR Edge-Interval Timer

This block measures the time between transitions on an infrared receiver input so that software can rebuild the mark/space train and decode any protocol itself. The input is synchronised, every transition restarts an interval counter, and on each transition of the selected polarity the block latches how long the segment that just ended lasted and whether that segment was a mark (input high) or a space (input low). It then raises a one-cycle event strobe.

Interval counting runs in ticks. A prescaler divides the clock so that one tick lasts `tick_div + 1` clock cycles. With a 1 MHz clock and `tick_div = 9` the resolution is 10 µs, which is the usual setting for raw capture. Capture runs only when the block is enabled and the mode input carries the raw-capture code. The intended bring-up order is reset first, then mode and rate, then enable.

Top module: `ir_edge_timer`

## Requirements
- R1: After reset, `interval` is 0, `pulse` is 0 and `event_stb` is 0.
- R2: Capture is active only while `enable` is 1 and `mode` equals 2 (raw code). Any other mode value, for example 0 (hardware-decoder code), or `enable` = 0 gives no events, holds the counter and prescaler at zero, and leaves `interval` and `pulse` unchanged.
- R3: One tick lasts `tick_div + 1` clock cycles. For a segment lasting H clock cycles between two detected edges, the latched `interval` is floor(H / (tick_div + 1)), counted from the edge that opened the segment.
- R4: `edge_sel` encoding: 1 = events on rising and falling edges, 2 = falling edges only, 3 = rising edges only, 0 = no edge events (value reserved for decoder-generated events).
- R5: On each event, `pulse` holds the level of the segment that just ended: 1 for a high segment (mark), 0 for a low segment (space).
- R6: Every detected transition restarts the interval counter and the prescaler, including transitions that `edge_sel` does not turn into events.
- R7: The interval counter saturates at 8191 (all ones in 13 bits) and never wraps, so a long idle segment reads as 8191.
- R8: `event_stb` is high for exactly one cycle per selected edge; between events `interval` and `pulse` hold their values.
- R9: A change of `ir_in` that is stable before a rising clock edge produces `event_stb` after the third rising edge counting that one (two synchroniser stages plus the event register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Capture enable |
| mode | input | 4 | Operating mode code; 2 selects raw capture |
| edge_sel | input | 2 | Event edge select (see R4) |
| tick_div | input | 12 | Tick length minus one, in clock cycles |
| ir_in | input | 1 | Asynchronous IR receiver input, high = mark |
| interval | output | 13 | Ticks in the segment that ended at the last event |
| pulse | output | 1 | Level of the segment that ended at the last event |
| event_stb | output | 1 | One-cycle strobe per selected edge |

## Verification
The embedded assertions check every cycle that an event coincides with a counter restart, that a saturated counter stays saturated, that the captured values hold between events, that no tick advances the count before the prescaler reaches its limit, and that an inactive mode or the reserved edge code yields no events. Only the bench's scenarios can show that the latched interval equals the real segment length for a given divider, that the pulse flag reports the correct level, that each edge-select value picks the right edges, that unselected edges still restart timing, and that the strobe appears exactly three edges after an input change; a behavioural reference model compared on every clock covers these along with directed checks of specific values.

// File: rtl/ir_edge_timer.sv
module ir_edge_timer #(
  parameter int CNT_W  = 13,
  parameter int DIV_W  = 12,
  parameter int MODE_W = 4,
  parameter logic [MODE_W-1:0] RAW_MODE = 4'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [MODE_W-1:0] mode,
  input  logic [1:0]        edge_sel,
  input  logic [DIV_W-1:0]  tick_div,
  input  logic              ir_in,
  output logic [CNT_W-1:0]  interval,
  output logic              pulse,
  output logic              event_stb
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             sync1, sync2, prev_lvl;
  logic [DIV_W-1:0] pre_cnt;
  logic [CNT_W-1:0] cnt;

  wire active   = enable && (mode == RAW_MODE);
  wire edge_any = sync2 ^ prev_lvl;
  wire is_rise  = sync2 & ~prev_lvl;
  wire tick     = (pre_cnt == tick_div);

  logic sel_hit;
  always_comb begin
    case (edge_sel)
      2'd1:    sel_hit = 1'b1;
      2'd2:    sel_hit = ~is_rise;
      2'd3:    sel_hit = is_rise;
      default: sel_hit = 1'b0;
    endcase
  end

  wire [CNT_W-1:0] cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  wire [CNT_W-1:0] cnt_now = tick ? cnt_inc : cnt;
  wire             fire    = active && edge_any && sel_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1    <= 1'b0;
      sync2    <= 1'b0;
      prev_lvl <= 1'b0;
    end else begin
      sync1    <= ir_in;
      sync2    <= sync1;
      prev_lvl <= sync2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active || edge_any) begin
      pre_cnt <= '0;
      cnt     <= '0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      cnt     <= cnt_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      interval  <= '0;
      pulse     <= 1'b0;
      event_stb <= 1'b0;
    end else begin
      event_stb <= fire;
      if (fire) begin
        interval <= cnt_now;
        pulse    <= prev_lvl;
      end
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!event_stb && cnt == '0));

  assert_tick_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !edge_any && pre_cnt != tick_div) |=> $stable(cnt));

  assert_sel_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == 2'd0) |=> !event_stb);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    event_stb |-> (cnt == '0 && pre_cnt == '0));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !edge_any && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !event_stb |-> ($stable(interval) && $stable(pulse)));

endmodule

// File: tb/test_ir_edge_timer.sv
module test_ir_edge_timer;
  localparam int CLK_PERIOD = 10;
  localparam int SAT = 8191;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic [1:0]  edge_sel = 2'd0;
  logic [11:0] tick_div = 12'd0;
  logic        ir_in = 1'b0;
  logic [12:0] interval;
  logic        pulse;
  logic        event_stb;

  ir_edge_timer i_ir_edge_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .edge_sel(edge_sel), .tick_div(tick_div), .ir_in(ir_in),
    .interval(interval), .pulse(pulse), .event_stb(event_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int ev_count = 0;
  int last_iv = 0;
  int last_pl = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_s1 = 0, m_s2 = 0, m_s3 = 0, m_pre = 0, m_cnt = 0;
  int m_iv = 0, m_pl = 0, m_stb = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pre = 0; m_cnt = 0;
      m_iv = 0; m_pl = 0; m_stb = 0;
    end else begin
      bit act, e, r, sel, tk;
      int now;
      act = enable && (mode == 4'd2);
      e   = (m_s2 != m_s3);
      r   = (m_s2 == 1) && (m_s3 == 0);
      sel = (edge_sel == 2'd1) || (edge_sel == 2'd2 && !r) || (edge_sel == 2'd3 && r);
      tk  = (m_pre == int'(tick_div));
      now = tk ? ((m_cnt + 1 > SAT) ? SAT : m_cnt + 1) : m_cnt;
      m_stb = (act && e && sel) ? 1 : 0;
      if (m_stb == 1) begin m_iv = now; m_pl = m_s3; end
      if (!act || e) begin m_pre = 0; m_cnt = 0; end
      else begin m_pre = tk ? 0 : m_pre + 1; m_cnt = now; end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(ir_in);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(int'(event_stb) == m_stb, "R8 strobe vs model", int'(event_stb), m_stb);
      chk(int'(interval) == m_iv, "R3 interval vs model", int'(interval), m_iv);
      chk(int'(pulse) == m_pl, "R5 pulse vs model", int'(pulse), m_pl);
      if (event_stb) begin
        ev_count++;
        last_iv = int'(interval);
        last_pl = int'(pulse);
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic seg(input bit lvl, input int n);
    ir_in = lvl;
    hold(n);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    hold(3);
    rst_n = 1'b1;
    hold(1);
    chk(interval == 0 && pulse == 0 && event_stb == 0, "R1 reset outputs",
        int'(interval) + int'(pulse) + int'(event_stb), 0);

    mode = 4'd2; tick_div = 12'd0; edge_sel = 2'd1;
    hold(2);
    enable = 1'b1;
    hold(10);
    seg(1'b1, 20);
    seg(1'b0, 6);
    chk(last_iv == 20, "R3 high segment div0", last_iv, 20);
    chk(last_pl == 1, "R5 mark level", last_pl, 1);
    hold(9);
    ir_in = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk(event_stb == 0, "R9 no strobe after two edges", int'(event_stb), 0);
    @(posedge clk); #1;
    chk(event_stb == 1, "R9 strobe after third edge", int'(event_stb), 1);
    hold(6);
    chk(last_iv == 15, "R3 low segment div0", last_iv, 15);
    chk(last_pl == 0, "R5 space level", last_pl, 0);

    tick_div = 12'd3;
    seg(1'b0, 40);
    seg(1'b1, 6);
    chk(last_iv == 10, "R3 div3 forty cycles", last_iv, 10);
    seg(1'b0, 22);
    seg(1'b1, 6);
    chk(last_iv == 5, "R3 div3 floor", last_iv, 5);

    tick_div = 12'd0; edge_sel = 2'd2;
    seg(1'b0, 12);
    base = ev_count;
    seg(1'b1, 25);
    seg(1'b0, 6);
    chk(ev_count - base == 1, "R4 falling only count", ev_count - base, 1);
    chk(last_iv == 25, "R6 restart on unselected rise", last_iv, 25);
    chk(last_pl == 1, "R5 falling ends mark", last_pl, 1);

    edge_sel = 2'd3;
    hold(24);
    base = ev_count;
    seg(1'b1, 8);
    seg(1'b0, 30);
    seg(1'b1, 6);
    chk(ev_count - base == 2, "R4 rising only count", ev_count - base, 2);
    chk(last_iv == 30, "R6 restart on unselected fall", last_iv, 30);
    chk(last_pl == 0, "R5 rising ends space", last_pl, 0);

    edge_sel = 2'd0;
    base = ev_count;
    for (int k = 0; k < 6; k++) seg(~ir_in, 7);
    chk(ev_count - base == 0, "R4 select zero silent", ev_count - base, 0);
    chk(last_iv == 30, "R8 interval held", last_iv, 30);

    edge_sel = 2'd1; mode = 4'd0;
    base = ev_count;
    for (int k = 0; k < 6; k++) seg(~ir_in, 7);
    chk(ev_count - base == 0, "R2 decoder mode silent", ev_count - base, 0);
    mode = 4'd2; enable = 1'b0;
    for (int k = 0; k < 6; k++) seg(~ir_in, 7);
    chk(ev_count - base == 0, "R2 disabled silent", ev_count - base, 0);
    chk(int'(interval) == 30, "R2 interval unchanged", int'(interval), 30);

    enable = 1'b1;
    hold(5);
    seg(~ir_in, 9000);
    seg(~ir_in, 6);
    chk(last_iv == SAT, "R7 saturation", last_iv, SAT);
    seg(~ir_in, 6);
    chk(last_iv == 6, "R7 counting resumes after saturation", last_iv, 6);

    hold(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule